// File: doc/BRIEF.md
# DCO Tap Modulation Sequencer

This block chooses, in every cycle, which of eight discrete frequency taps a digitally controlled oscillator should use. A single byte-wide control register holds a base tap number and a modulation count. Time is divided into frames of 32 cycles. In each frame the block selects the next tap up for exactly as many cycles as the modulation count says, and the base tap for the rest. The average output frequency therefore lies between two adjacent taps. When the base tap is already the highest tap, no modulation happens.

The block runs on the oscillator's own output clock and has a synchronous reset. Software reads and writes the control byte through a plain byte bus port at one address, and may do so at any time. A written value is held in the register at once. The sequencer only uses it from the start of the next frame, so a frame never mixes two settings. A one-cycle strobe marks the first cycle of every frame. The bus is a simple register port with no handshake: a write completes in the cycle it is presented and a read returns data in the same cycle.

Top module: `dco_mod_seq`

## Requirements
- R1: After a synchronous reset the register reads 0x60 (base tap 3, modulation count 0) and the first cycle after reset is the first cycle of a frame.
- R2: The control byte holds the base tap in bits 7:5 and the modulation count in bits 4:0. It is written when `bus_wr` is high and `bus_addr` equals 0x56, and the value reads back on `bus_rdata` in the following cycle. `bus_rdata` is 0 for any other address, and writes to any other address leave the register unchanged.
- R3: In each 32-cycle frame with a base tap below 7, the output equals base tap + 1 in exactly MOD cycles.
- R4: In every other cycle of such a frame the output equals the base tap. No other value ever appears.
- R5: The higher tap is used in frame cycle k (k = 0..31) exactly when floor((k+1)·MOD/32) > floor(k·MOD/32).
- R6: With base tap 7 the output is 7 in all 32 cycles, whatever MOD is.
- R7: With MOD = 0 the output is the base tap in every cycle of the frame.
- R8: A write changes the output only from the first cycle of the next frame. A write made in the last cycle of a frame (cycle 31) applies to the frame that follows immediately.
- R9: `frame_start` is high in frame cycle 0 and low in cycles 1 to 31, so it pulses once every 32 cycles.
- R10: A reset asserted in the middle of a frame restores the register to 0x60 and starts a new frame in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator output clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte bus address |
| bus_wr | input | 1 | Write enable for the byte bus |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: the control byte when the address matches, otherwise 0 |
| tap_sel | output | 3 | Tap selected for the current cycle |
| frame_start | output | 1 | High in the first cycle of each 32-cycle frame |

## Verification
Two events can land in the same cycle: a register write and the frame wrap. The bench sweeps all 256 control values and moves the write position through the frame. Each write comes in cycle (value mod 32), so many writes fall in cycle 31, right at the wrap. For every frame the bench predicts all 32 outputs from the floor formula. The cycles after a write must still follow the old value until the wrap, and the very next frame must follow the new one. Mid-frame reset and writes to a foreign address are checked separately.

// File: rtl/dco_mod_pkg.sv
package dco_mod_pkg;
  localparam int unsigned TAP_BITS  = 3;
  localparam int unsigned CNT_BITS  = 5;
  localparam int unsigned BYTE_BITS = TAP_BITS + CNT_BITS;
  localparam int unsigned ADDR_BITS = 8;
  localparam logic [ADDR_BITS-1:0] CTRL_ADDR  = 8'h56;
  localparam logic [BYTE_BITS-1:0] CTRL_RESET = 8'h60;
endpackage

// File: rtl/dco_ctrl_reg.sv
module dco_ctrl_reg #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter logic [DATA_W-1:0] RST_VAL  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] reg_q,
  output logic [DATA_W-1:0] reg_next
);
  logic hit;

  assign hit      = (bus_addr == REG_ADDR);
  assign reg_next = (hit && bus_wr) ? bus_wdata : reg_q;

  always_ff @(posedge clk) begin
    if (rst) reg_q <= RST_VAL;
    else     reg_q <= reg_next;
  end

  assign bus_rdata = hit ? reg_q : '0;
endmodule

// File: rtl/dco_frame_timer.sv
module dco_frame_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             first,
  output logic             last
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign first = (cnt == '0);
  assign last  = (cnt == CNT_MAX);
endmodule

// File: rtl/dco_dither_core.sv
module dco_dither_core #(
  parameter int unsigned TAP_W = 3,
  parameter int unsigned MOD_W = 5,
  parameter logic [TAP_W+MOD_W-1:0] RST_WORD = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [TAP_W+MOD_W-1:0] load_word,
  output logic [TAP_W-1:0]       act_tap,
  output logic [MOD_W-1:0]       act_mod,
  output logic [TAP_W-1:0]       tap_sel
);
  localparam logic [TAP_W-1:0] TAP_TOP = '1;

  logic [MOD_W-1:0] acc;
  logic [MOD_W:0]   sum;
  logic             carry;
  logic             at_top;

  assign sum    = {1'b0, acc} + {1'b0, act_mod};
  assign carry  = sum[MOD_W];
  assign at_top = (act_tap == TAP_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_tap <= RST_WORD[TAP_W+MOD_W-1:MOD_W];
      act_mod <= RST_WORD[MOD_W-1:0];
      acc     <= '0;
    end else if (load) begin
      act_tap <= load_word[TAP_W+MOD_W-1:MOD_W];
      act_mod <= load_word[MOD_W-1:0];
      acc     <= '0;
    end else begin
      acc     <= sum[MOD_W-1:0];
    end
  end

  always_comb begin
    if (at_top) tap_sel = act_tap;
    else        tap_sel = act_tap + {{(TAP_W-1){1'b0}}, carry};
  end
endmodule

// File: rtl/dco_mod_seq.sv
module dco_mod_seq
  import dco_mod_pkg::*;
#(
  parameter int unsigned TAP_W = TAP_BITS,
  parameter int unsigned MOD_W = CNT_BITS,
  parameter int unsigned ADDR_W = ADDR_BITS,
  parameter logic [ADDR_W-1:0] REG_ADDR = CTRL_ADDR,
  parameter logic [TAP_W+MOD_W-1:0] RST_VAL = CTRL_RESET
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [TAP_W+MOD_W-1:0] bus_wdata,
  output logic [TAP_W+MOD_W-1:0] bus_rdata,
  output logic [TAP_W-1:0]       tap_sel,
  output logic                   frame_start
);
  localparam int unsigned DATA_W = TAP_W + MOD_W;

  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] reg_next;
  logic [MOD_W-1:0]  frame_cnt;
  logic              frame_last;
  logic [TAP_W-1:0]  act_tap;
  logic [MOD_W-1:0]  act_mod;

  dco_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .RST_VAL(RST_VAL)
  ) u_reg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reg_q(reg_q), .reg_next(reg_next)
  );

  dco_frame_timer #(.CNT_W(MOD_W)) u_timer (
    .clk(clk), .rst(rst), .cnt(frame_cnt),
    .first(frame_start), .last(frame_last)
  );

  dco_dither_core #(.TAP_W(TAP_W), .MOD_W(MOD_W), .RST_WORD(RST_VAL)) u_core (
    .clk(clk), .rst(rst), .load(frame_last), .load_word(reg_next),
    .act_tap(act_tap), .act_mod(act_mod), .tap_sel(tap_sel)
  );
endmodule

// File: rtl/dco_mod_seq_chk.sv
module dco_mod_seq_chk #(
  parameter int unsigned TAP_W = 3,
  parameter int unsigned MOD_W = 5,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter logic [TAP_W+MOD_W-1:0] RST_VAL = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_wr,
  input logic [TAP_W+MOD_W-1:0] bus_wdata,
  input logic [TAP_W+MOD_W-1:0] reg_q,
  input logic [TAP_W-1:0]       act_tap,
  input logic [MOD_W-1:0]       act_mod,
  input logic [TAP_W-1:0]       tap_sel,
  input logic                   frame_start
);
  localparam logic [TAP_W-1:0] TOP = '1;
  localparam logic [TAP_W-1:0] ONE = 1;

  assert_reset_restores_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg_q == RST_VAL && frame_start));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_ADDR) |=> (reg_q == $past(bus_wdata)));

  assert_tap_adjacent_R4: assert property (@(posedge clk) disable iff (rst)
    (act_tap != TOP) |-> (tap_sel == act_tap || tap_sel == act_tap + ONE));

  assert_top_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (act_tap == TOP) |-> (tap_sel == TOP));

  assert_flat_when_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (act_mod == '0) |-> (tap_sel == act_tap));

  assert_frame_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_start |-> $stable({act_tap, act_mod}));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
endmodule

bind dco_mod_seq dco_mod_seq_chk #(
  .TAP_W(TAP_W), .MOD_W(MOD_W), .ADDR_W(ADDR_W),
  .REG_ADDR(REG_ADDR), .RST_VAL(RST_VAL)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .reg_q(reg_q), .act_tap(act_tap),
  .act_mod(act_mod), .tap_sel(tap_sel), .frame_start(frame_start)
);

// File: tb/test_dco_mod_seq.sv
`timescale 1ns/1ps
module test_dco_mod_seq;
  localparam logic [7:0] ADDR = 8'h56;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [2:0] tap_sel;
  logic       frame_start;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dco_mod_seq i_dco_mod_seq (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tap_sel(tap_sel), .frame_start(frame_start)
  );

  function automatic int exp_tap(input logic [7:0] v, input int k);
    int t, m;
    t = v[7:5];
    m = v[4:0];
    if (t == 7) return 7;
    return t + ((((k + 1) * m) / 32 != (k * m) / 32) ? 1 : 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One frame, sampled at negedges from frame cycle 0. Output follows 'cur';
  // optionally a write of 'nv' is driven in cycle kw (it must not alter this frame: R8).
  task automatic run_frame(input logic [7:0] cur, input bit do_wr,
                           input int kw, input logic [7:0] nv);
    int highs = 0;
    string tag;
    for (int k = 0; k < 32; k++) begin
      if (cur[7:5] == 3'd7)      tag = "R6";
      else if (cur[4:0] == 5'd0) tag = "R7";
      else                       tag = "R5";
      if (do_wr && k > kw) tag = "R8";
      check("R9", int'(frame_start), (k == 0) ? 1 : 0);
      check(tag, int'(tap_sel), exp_tap(cur, k));
      if (cur[7:5] != 3'd7 && int'(tap_sel) == int'(cur[7:5]) + 1) highs++;
      if (int'(tap_sel) != int'(cur[7:5]) && int'(tap_sel) != int'(cur[7:5]) + 1)
        check("R4", int'(tap_sel), int'(cur[7:5]));
      if (do_wr && k == kw) begin
        bus_addr  = ADDR;
        bus_wdata = nv;
        bus_wr    = 1'b1;
      end
      @(negedge clk);
      bus_wr = 1'b0;
    end
    check("R3", highs, (cur[7:5] == 3'd7) ? 0 : int'(cur[4:0]));
  endtask

  initial begin
    logic [7:0] prev;
    rst = 1'b1; bus_addr = ADDR; bus_wr = 1'b0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", int'(bus_rdata), 8'h60);
    check("R1", int'(frame_start), 1);
    check("R1", int'(tap_sel), 3);
    @(negedge clk);
    while (!frame_start) @(negedge clk);

    // Sweep all 256 values; write position moves with the value (cycle v%32).
    prev = 8'h60;
    for (int v = 0; v < 256; v++) begin
      run_frame(prev, 1'b1, v % 32, 8'(v));
      prev = 8'(v);
    end
    run_frame(prev, 1'b0, 0, 8'h00);

    // R2: readback, foreign address read and write.
    bus_addr = ADDR; #1;
    check("R2", int'(bus_rdata), int'(prev));
    bus_addr = 8'h57; #1;
    check("R2", int'(bus_rdata), 0);
    bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = ADDR; #1;
    check("R2", int'(bus_rdata), int'(prev));
    while (!frame_start) @(negedge clk);
    run_frame(prev, 1'b1, 3, 8'h4B);
    bus_addr = ADDR; #1;
    check("R2", int'(bus_rdata), 8'h4B);
    run_frame(8'h4B, 1'b0, 0, 8'h00);

    // R10: reset in the middle of a frame.
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; #1;
    check("R10", int'(bus_rdata), 8'h60);
    check("R10", int'(frame_start), 1);
    run_frame(8'h60, 1'b0, 0, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule